// File: doc/BRIEF.md
# Three-Wire Control Word Transmitter

This block is the host side of a three-wire control port made of a clock line, a data line and a latch line. It takes a parallel control word through a valid/ready handshake. It shifts the word out most significant bit first, so that the receiver samples each bit on a rising edge of the serial clock. After the last bit it raises a latch pulse, and it leaves clock and data low.

The receiving side sets minimum widths for the clock phases, the data bits, the setup before a clock rise, the hold after it, and the gap before the latch. The block converts each of these minimums into a whole number of system-clock cycles. It does this once at elaboration, from a clock-frequency parameter, rounding up and never below one cycle. One down-counter, reloaded at every phase change, times the whole sequence. The word width is also a parameter.

A user presents a word with `in_valid`. The word is taken on the first edge where `in_ready` is also high. `done` pulses once when the transfer is complete.

Top module: `ctl_word_tx`

## Requirements
- R1: While and after reset, `in_ready` is 1 and `ser_clk`, `ser_dat`, `ser_lat` and `done` are 0.
- R2: A word is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle after the `done` pulse. `in_valid` and `in_word` have no effect while `in_ready` is 0.
- R3: Bits appear on `ser_dat` most significant bit first, with bit index WORD_W-1 leading. Each bit is driven for a whole clock-low phase followed by a whole clock-high phase.
- R4: Let f be `CLK_HZ`. The clock-high phase lasts N_HIGH = ceil(2 µs·f) cycles. Each clock-low phase before a rise lasts N_LOW = max(ceil(2 µs·f), ceil(4 µs·f) − N_HIGH) cycles. Every count is at least 1. The first low phase starts in the cycle after acceptance.
- R5: After the last clock-high phase, clock and data are both 0 for N_SET = ceil(1 µs·f) cycles. Then `ser_lat` is 1 for N_LAT = ceil(2 µs·f) cycles.
- R6: `ser_lat` is never 1 while `ser_clk` is 1.
- R7: In the cycle after `ser_lat` falls, `ser_clk` and `ser_dat` are 0 and `done` is 1 for exactly one cycle. `in_ready` is 1 in the following cycle.
- R8: `ser_dat` does not change while `ser_clk` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Block is idle and will take a word |
| in_word | input | WORD_W | Control word to send |
| ser_clk | output | 1 | Serial clock line |
| ser_dat | output | 1 | Serial data line |
| ser_lat | output | 1 | Latch line |
| done | output | 1 | One-cycle pulse after the latch falls |

## Verification
A wrong state or a wrong counter value shows up at the serial ports in the same cycle. The cause may be a phase that is skipped, repeated or reloaded with the wrong count. The reason is that the bench model predicts all three lines, `in_ready` and `done` for every cycle after acceptance. A shift register that is off by one position changes `ser_dat` in the first low phase where the bit differs. An early return to idle raises `in_ready` before the model expects it, and a handshake leak starts a waveform that the model never queued.

// File: rtl/ctl_tx_pkg.sv
`timescale 1ns/1ps
package ctl_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLK_HIGH,
        ST_CLK_LOW,
        ST_LAT_SETUP,
        ST_LAT_HIGH,
        ST_DONE
    } tx_state_e;

    // Whole cycles covering ns nanoseconds at hz, rounded up, never below one.
    function automatic int phase_cycles(input int ns, input int unsigned hz);
        longint p;
        p = longint'(ns);
        p = p * longint'(hz);
        p = (p + 64'sd999_999_999) / 64'sd1_000_000_000;
        if (p < 1) p = 1;
        return int'(p);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ctl_tx_timer.sv
`timescale 1ns/1ps
module ctl_tx_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ctl_tx_shifter.sv
`timescale 1ns/1ps
module ctl_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              msb,
    output logic              last
);
    localparam int IDX_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= word;
            idx  <= '0;
        end else if (shift) begin
            sreg <= sreg << 1;
            idx  <= idx + 1'b1;
        end
    end

    assign msb  = sreg[WORD_W-1];
    assign last = (idx == IDX_W'(WORD_W - 1));
endmodule

// File: rtl/ctl_tx_fsm.sv
`timescale 1ns/1ps
module ctl_tx_fsm
    import ctl_tx_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int N_LOW  = 1,
    parameter int N_HIGH = 1,
    parameter int N_SET  = 1,
    parameter int N_LAT  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             expired,
    input  logic             last_bit,
    output tx_state_e        state,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             w_load,
    output logic             w_shift
);
    tx_state_e nxt;

    always_comb begin
        nxt     = state;
        t_load  = 1'b0;
        t_val   = '0;
        w_load  = 1'b0;
        w_shift = 1'b0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                nxt    = ST_SETUP;
                t_load = 1'b1;
                t_val  = CNT_W'(N_LOW - 1);
                w_load = 1'b1;
            end
            ST_SETUP, ST_CLK_LOW: if (expired) begin
                nxt    = ST_CLK_HIGH;
                t_load = 1'b1;
                t_val  = CNT_W'(N_HIGH - 1);
            end
            ST_CLK_HIGH: if (expired) begin
                t_load = 1'b1;
                if (last_bit) begin
                    nxt   = ST_LAT_SETUP;
                    t_val = CNT_W'(N_SET - 1);
                end else begin
                    nxt     = ST_CLK_LOW;
                    t_val   = CNT_W'(N_LOW - 1);
                    w_shift = 1'b1;
                end
            end
            ST_LAT_SETUP: if (expired) begin
                nxt    = ST_LAT_HIGH;
                t_load = 1'b1;
                t_val  = CNT_W'(N_LAT - 1);
            end
            ST_LAT_HIGH: if (expired) nxt = ST_DONE;
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/ctl_word_tx.sv
`timescale 1ns/1ps
module ctl_word_tx
    import ctl_tx_pkg::*;
#(
    parameter int          WORD_W = 16,
    parameter int unsigned CLK_HZ = 125_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              ser_lat,
    output logic              done
);
    localparam int N_HIGH = phase_cycles(2000, CLK_HZ);
    localparam int N_LOW  = max2(phase_cycles(2000, CLK_HZ),
                                 phase_cycles(4000, CLK_HZ) - N_HIGH);
    localparam int N_SET  = phase_cycles(1000, CLK_HZ);
    localparam int N_LAT  = phase_cycles(2000, CLK_HZ);
    localparam int N_MAX  = max2(max2(N_HIGH, N_LOW), max2(N_SET, N_LAT));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    tx_state_e        state;
    logic             t_load, expired, w_load, w_shift, msb, last_bit;
    logic [CNT_W-1:0] t_val;

    ctl_tx_fsm #(
        .CNT_W(CNT_W), .N_LOW(N_LOW), .N_HIGH(N_HIGH),
        .N_SET(N_SET), .N_LAT(N_LAT)
    ) u_fsm (
        .clk(clk), .rst(rst), .in_valid(in_valid), .expired(expired),
        .last_bit(last_bit), .state(state), .t_load(t_load), .t_val(t_val),
        .w_load(w_load), .w_shift(w_shift)
    );

    ctl_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(expired)
    );

    ctl_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(w_load), .word(in_word), .shift(w_shift),
        .msb(msb), .last(last_bit)
    );

    assign in_ready = (state == ST_IDLE);
    assign ser_clk  = (state == ST_CLK_HIGH);
    assign ser_lat  = (state == ST_LAT_HIGH);
    assign done     = (state == ST_DONE);
    assign ser_dat  = msb & ((state == ST_SETUP) || (state == ST_CLK_LOW) ||
                             (state == ST_CLK_HIGH));

    // R6: latch only inside a clock-low interval
    p_lat_clk_low_r6: assert property (@(posedge clk) disable iff (rst)
        ser_lat |-> !ser_clk);
    // R7: lines low and done raised once the latch drops
    p_after_lat_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_lat) |-> (!ser_clk && !ser_dat && done));
    // R7: done lasts one cycle, then ready returns
    p_done_once_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && in_ready));
    // R2: no handshake while the bus is in use
    p_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (ser_clk || ser_lat || done) |-> !in_ready);
    // R8: data hold across the high phase
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));
    // R5: latch rises only after a low-clock, low-data gap
    p_lat_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_lat) |-> ($past(!ser_clk) && $past(!ser_dat)));
endmodule

// File: tb/sim_ctl_word_tx.sv
`timescale 1ns/1ps
module sim_ctl_word_tx;
    localparam int          W  = 12;
    localparam int unsigned HZ = 3_300_000;

    function automatic int cyc(input int ns);
        longint t;
        t = (longint'(ns) * longint'(HZ) + 64'sd999_999_999) / 64'sd1_000_000_000;
        return (t < 1) ? 1 : int'(t);
    endfunction

    localparam int NH  = 7;   // ceil(6.6)
    localparam int NL  = 7;   // max(7, ceil(13.2)-7)
    localparam int NTS = 4;   // ceil(3.3)
    localparam int NLW = 7;   // ceil(6.6)

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst, in_valid, in_ready, ser_clk, ser_dat, ser_lat, done;
    logic [W-1:0] in_word;

    ctl_word_tx #(.WORD_W(W), .CLK_HZ(HZ)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_lat(ser_lat), .done(done)
    );

    // expected vector: {clk, dat, lat, ready, done}
    localparam logic [4:0] IDLE_V = 5'b00010;
    logic [4:0] q[$];
    logic [4:0] cur = IDLE_V;
    int  checks = 0, errors = 0;
    bit  finished = 0, last_acc = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_word(input logic [W-1:0] w);
        for (int b = W - 1; b >= 0; b--) begin
            repeat (NL) q.push_back({1'b0, w[b], 3'b000});
            repeat (NH) q.push_back({1'b1, w[b], 3'b000});
        end
        repeat (NTS) q.push_back(5'b00000);
        repeat (NLW) q.push_back(5'b00100);
        q.push_back(5'b00001);
    endtask

    task automatic tick();
        bit acc;
        logic [W-1:0] w;
        @(posedge clk);
        acc = cur[1] && in_valid;
        w   = in_word;
        @(negedge clk);
        if (acc) push_word(w);
        last_acc = acc;
        cur = (q.size() != 0) ? q.pop_front() : IDLE_V;
        chk(ser_clk == cur[4], "R4", "ser_clk", ser_clk, cur[4]);
        chk(ser_dat == cur[3], "R3", "ser_dat", ser_dat, cur[3]);
        chk(ser_lat == cur[2], "R5", "ser_lat", ser_lat, cur[2]);
        chk(in_ready == cur[1], "R2", "in_ready", in_ready, cur[1]);
        chk(done == cur[0], "R7", "done", done, cur[0]);
        chk(!(ser_lat && ser_clk), "R6", "lat_and_clk", ser_lat & ser_clk, 0);
        if (ser_clk && prev_clk)
            chk(ser_dat == prev_dat, "R8", "dat_hold", ser_dat, prev_dat);
        prev_clk = ser_clk;
        prev_dat = ser_dat;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) tick();
        repeat (3) tick();
    endtask

    task automatic send(input logic [W-1:0] w, input bit poke_busy);
        in_valid = 1'b1;
        in_word  = w;
        do tick(); while (!last_acc);
        if (poke_busy) begin
            in_word = ~w;          // R2: offered while busy, must be ignored
            repeat (60) tick();
        end
        in_valid = 1'b0;
        wait_idle();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_word = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        chk({ser_clk, ser_dat, ser_lat, done} == 4'b0,
            "R1", "lines", {ser_clk, ser_dat, ser_lat, done}, 0);
        rst = 1'b0;
        chk(NH == cyc(2000) && NTS == cyc(1000), "R4", "count_table", NH, cyc(2000));
        repeat (4) tick();
        send(12'hA5C, 1'b0);
        send(12'h000, 1'b1);
        send(12'hFFF, 1'b0);
        send(12'h801, 1'b1);
        send(12'h001, 1'b0);
        // back-to-back: valid held over two words
        in_valid = 1'b1; in_word = 12'h3C3;
        do tick(); while (!last_acc);
        in_word = 12'h5A5;
        do tick(); while (!last_acc);
        in_valid = 1'b0;
        wait_idle();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end
endmodule